// File: doc/BRIEF.md
# Dual-Sided Inter-Core Messaging Unit

This block links two processor sides, called A and B, each with a small register port of its own. It carries 32-bit words through four one-word mailbox slots per direction. Each slot has a one-bit handshake: the writer fills the slot, the reader drains it, and each side can see the result in its status register. Each side also publishes a 3-bit flag value to its partner. A new flag value is copied across after a fixed propagation delay. While that copy is in progress, a busy bit is set and further flag changes are refused.

The block also carries doorbell interrupts in both directions. A side can raise any of four general-purpose requests and one non-maskable request toward its partner. A raised bit stays set in the requester's control register until the partner acknowledges it by writing 1 to the matching pending bit in its own status register. This gives the requester a reliable "still in flight" indication. Each side has one maskable interrupt output and one non-maskable interrupt output.

Register map per side (address on `x_addr`):
- Addresses 0 to 3 select mailbox slot n. A write fills the outgoing slot n. A read returns the incoming slot n.
- Address 4 is the control register.
- Address 5 is the status register.
- Other addresses read as zero.

Top module: `mu_dual_top`

## Requirements
- R1: After reset, both status registers read 0x00F00000 (all four outgoing slots empty, nothing else set), both control registers read 0, and all four interrupt outputs are low.
- R2: A write to slot n (address n) stores the word when the outgoing slot is empty. From the next cycle the writer's status bit 23-n reads 0 and the partner's status bit 27-n reads 1. A write to a slot that is still occupied is ignored, and the stored word is kept.
- R3: A read of slot n returns the word the partner stored. If the slot was full, the reader's status bit 27-n reads 0 from the next cycle and the writer's status bit 23-n reads 1.
- R4: Status bits for slot or request n sit in descending order below a fixed top bit: outgoing-empty at bit 23-n, incoming-full at bit 27-n, general request pending at bit 31-n.
- R5: When a control write carries a value in bits 2:0 that differs from the current flags, the writer's status bit 4 (busy) reads 1 for PROP_CYCLES cycles. After that, the partner's status bits 2:0 show the new value and busy returns to 0.
- R6: While busy is set, the flag field of a control write is ignored, while the other fields of the same write still take effect.
- R7: Writing 1 to control bit 19-g raises general request g. The partner's status bit 31-g then reads 1. The request stays set through writes of 0 to that bit, and through partner status writes of 0. It clears only when the partner writes 1 to status bit 31-g.
- R8: Control bit 3 raises a non-maskable request. It drives the partner's non-maskable output and the partner's status bit 3 until the partner writes 1 to its status bit 3.
- R9: The maskable output of a side is the OR of three terms:
  - incoming-full slot n, enabled by control bit 23-n;
  - pending request g, enabled by control bit 27-g;
  - the flag-change event, enabled by control bit 28.
- R10: Status bit 5 becomes set when the partner's flags seen by this side change. It stays set until this side writes 1 to status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 3 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the cycle of the access |
| a_irq | output | 1 | Side A maskable interrupt |
| a_nmi | output | 1 | Side A non-maskable interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 3 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the cycle of the access |
| b_irq | output | 1 | Side B maskable interrupt |
| b_nmi | output | 1 | Side B non-maskable interrupt |

## Verification
The in-line properties check the following on every cycle:
- A write to an occupied slot leaves its stored word unchanged.
- Reading a full slot empties it.
- Flags stay frozen while busy, and the far copy matches the local value when busy drops.
- A general request never drops without an acknowledge.
- The flag-change event is sticky.

The exact bit positions, the propagation delay in cycles, and the interaction of busy release with a write in the same cycle can only be shown by the bench's scenarios. The same holds for read-modify-write of the control register leaving requests intact, and the enable gating of the interrupt outputs. All of these are compared against a behavioural model on every clock.

// File: rtl/mu_pkg.sv
package mu_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int FLAG_W   = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

    // status layout: per-index groups descend from their top bit
    localparam int ST_TXE_TOP = 23;
    localparam int ST_RXF_TOP = 27;
    localparam int ST_GPP_TOP = 31;
    localparam int ST_NMI     = 3;
    localparam int ST_BUSY    = 4;
    localparam int ST_EVT     = 5;

    // control layout
    localparam int CT_NMI     = 3;
    localparam int CT_GPR_TOP = 19;
    localparam int CT_RXE_TOP = 23;
    localparam int CT_GPE_TOP = 27;
    localparam int CT_FEE     = 28;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mu_bus_t;

    // bit position of index n in a group whose index 0 sits at top
    function automatic int grp_bit(input int top, input int n);
        return top - n;
    endfunction

endpackage

// File: rtl/mu_msg_channel.sv
module mu_msg_channel #(
    parameter int N_SLOTS = 4,
    parameter int W       = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_SLOTS-1:0]        wr_en,
    input  logic [W-1:0]              wr_data,
    input  logic [N_SLOTS-1:0]        rd_en,
    output logic [N_SLOTS-1:0]        occ_o,
    output logic [N_SLOTS-1:0][W-1:0] data_o
);

    for (genvar n = 0; n < N_SLOTS; n++) begin : g_slot
        logic         occ_q;
        logic [W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q  <= 1'b0;
                data_q <= '0;
            end else if (wr_en[n] && !occ_q) begin
                occ_q  <= 1'b1;
                data_q <= wr_data;
            end else if (rd_en[n] && occ_q) begin
                occ_q  <= 1'b0;
            end
        end

        assign occ_o[n]  = occ_q;
        assign data_o[n] = data_q;

        // R2: an occupied slot keeps its word when written again
        p_no_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en[n] && occ_o[n]) |=> $stable(data_o[n]));

        // R3: draining a full slot leaves it empty
        p_read_drains_r3: assert property (@(posedge clk) disable iff (rst)
            (rd_en[n] && occ_o[n]) |=> !occ_o[n]);
    end

endmodule

// File: rtl/mu_side.sv
module mu_side
    import mu_pkg::*;
#(
    parameter int N_SLOTS     = 4,
    parameter int N_GPI       = 4,
    parameter int PROP_CYCLES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  mu_bus_t                        bus_i,
    output logic [DATA_W-1:0]              rdata_o,
    // incoming channel (partner writes, this side reads)
    input  logic [N_SLOTS-1:0]             rx_full_i,
    input  logic [N_SLOTS-1:0][DATA_W-1:0] rx_data_i,
    output logic [N_SLOTS-1:0]             rx_rd_o,
    // outgoing channel (this side writes)
    input  logic [N_SLOTS-1:0]             tx_occ_i,
    output logic [N_SLOTS-1:0]             tx_wr_o,
    output logic [DATA_W-1:0]              tx_data_o,
    // flags
    output logic [FLAG_W-1:0]              flags_far_o,
    input  logic [FLAG_W-1:0]              flags_far_i,
    // doorbells
    output logic [N_GPI-1:0]               gp_req_o,
    input  logic [N_GPI-1:0]               gp_pend_i,
    output logic [N_GPI-1:0]               gp_ack_o,
    input  logic [N_GPI-1:0]               gp_ack_i,
    output logic                           nmi_req_o,
    input  logic                           nmi_pend_i,
    output logic                           nmi_ack_o,
    input  logic                           nmi_ack_i,
    output logic                           irq_o
);

    localparam int CNT_W = $clog2(PROP_CYCLES + 1);

    logic ctrl_wr, stat_wr;
    logic [FLAG_W-1:0] w_flags;
    logic [N_GPI-1:0]  w_gp_set, w_gp_ack, w_gpen;
    logic [N_SLOTS-1:0] w_rxen;

    logic [FLAG_W-1:0] flags_q, far_q, prev_q;
    logic              busy_q, evt_q, nmi_q, fee_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [N_GPI-1:0]  gp_req_q, gpen_q;
    logic [N_SLOTS-1:0] rxen_q;
    logic [DATA_W-1:0] ctrl_word, stat_word;

    assign ctrl_wr   = bus_i.sel && bus_i.we && (bus_i.addr == ADDR_CTRL);
    assign stat_wr   = bus_i.sel && bus_i.we && (bus_i.addr == ADDR_STAT);
    assign w_flags   = bus_i.wdata[FLAG_W-1:0];
    assign tx_data_o = bus_i.wdata;

    always_comb begin
        for (int n = 0; n < N_SLOTS; n++) begin
            tx_wr_o[n] = bus_i.sel &&  bus_i.we && (bus_i.addr == ADDR_W'(n));
            rx_rd_o[n] = bus_i.sel && !bus_i.we && (bus_i.addr == ADDR_W'(n));
            w_rxen[n]  = bus_i.wdata[grp_bit(CT_RXE_TOP, n)];
        end
        for (int g = 0; g < N_GPI; g++) begin
            w_gp_set[g] = bus_i.wdata[grp_bit(CT_GPR_TOP, g)];
            w_gpen[g]   = bus_i.wdata[grp_bit(CT_GPE_TOP, g)];
            w_gp_ack[g] = bus_i.wdata[grp_bit(ST_GPP_TOP, g)];
        end
    end

    assign gp_ack_o  = stat_wr ? (w_gp_ack & gp_pend_i) : '0;
    assign nmi_ack_o = stat_wr && bus_i.wdata[ST_NMI] && nmi_pend_i;

    // flag value and its delayed copy toward the partner
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            far_q   <= '0;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(1)) begin
                far_q  <= flags_q;
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end else if (ctrl_wr && (w_flags != flags_q)) begin
            flags_q <= w_flags;
            busy_q  <= 1'b1;
            cnt_q   <= CNT_W'(PROP_CYCLES);
        end
    end

    assign flags_far_o = far_q;

    // control fields, requests and the change event
    always_ff @(posedge clk) begin
        if (rst) begin
            rxen_q   <= '0;
            gpen_q   <= '0;
            fee_q    <= 1'b0;
            gp_req_q <= '0;
            nmi_q    <= 1'b0;
            prev_q   <= '0;
            evt_q    <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                rxen_q <= w_rxen;
                gpen_q <= w_gpen;
                fee_q  <= bus_i.wdata[CT_FEE];
            end
            gp_req_q <= (gp_req_q | (ctrl_wr ? w_gp_set : '0)) & ~gp_ack_i;
            nmi_q    <= (nmi_q | (ctrl_wr && bus_i.wdata[CT_NMI])) & ~nmi_ack_i;
            prev_q   <= flags_far_i;
            evt_q    <= (evt_q & ~(stat_wr && bus_i.wdata[ST_EVT]))
                      | (flags_far_i != prev_q);
        end
    end

    assign gp_req_o  = gp_req_q;
    assign nmi_req_o = nmi_q;
    assign irq_o     = (|(rx_full_i & rxen_q)) | (|(gp_pend_i & gpen_q)) | (evt_q & fee_q);

    // register images
    always_comb begin
        ctrl_word = '0;
        stat_word = '0;
        ctrl_word[FLAG_W-1:0] = flags_q;
        ctrl_word[CT_NMI]     = nmi_q;
        ctrl_word[CT_FEE]     = fee_q;
        stat_word[FLAG_W-1:0] = flags_far_i;
        stat_word[ST_NMI]     = nmi_pend_i;
        stat_word[ST_BUSY]    = busy_q;
        stat_word[ST_EVT]     = evt_q;
        for (int n = 0; n < N_SLOTS; n++) begin
            ctrl_word[grp_bit(CT_RXE_TOP, n)] = rxen_q[n];
            stat_word[grp_bit(ST_TXE_TOP, n)] = !tx_occ_i[n];
            stat_word[grp_bit(ST_RXF_TOP, n)] = rx_full_i[n];
        end
        for (int g = 0; g < N_GPI; g++) begin
            ctrl_word[grp_bit(CT_GPR_TOP, g)] = gp_req_q[g];
            ctrl_word[grp_bit(CT_GPE_TOP, g)] = gpen_q[g];
            stat_word[grp_bit(ST_GPP_TOP, g)] = gp_pend_i[g];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (bus_i.addr == ADDR_CTRL) begin
            rdata_o = ctrl_word;
        end else if (bus_i.addr == ADDR_STAT) begin
            rdata_o = stat_word;
        end else begin
            for (int n = 0; n < N_SLOTS; n++) begin
                if (bus_i.addr == ADDR_W'(n)) rdata_o = rx_data_i[n];
            end
        end
    end

    // R6: flags frozen while a propagation is in flight
    p_flags_locked_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ctrl_wr) |=> (flags_q == $past(flags_q)));

    // R5: when busy ends the partner copy equals the local value
    p_far_on_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (flags_far_o == flags_q));

    // R10: the change event stays until cleared
    p_evt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !(stat_wr && bus_i.wdata[ST_EVT])) |=> evt_q);

    for (genvar g = 0; g < N_GPI; g++) begin : g_chk
        // R7: a raised request drops only on acknowledge
        p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
            (gp_req_o[g] && !gp_ack_i[g]) |=> gp_req_o[g]);
    end

endmodule

// File: rtl/mu_dual_top.sv
module mu_dual_top
    import mu_pkg::*;
#(
    parameter int N_SLOTS     = 4,
    parameter int N_GPI       = 4,
    parameter int PROP_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        a_sel,
    input  logic        a_we,
    input  logic [2:0]  a_addr,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_irq,
    output logic        a_nmi,
    input  logic        b_sel,
    input  logic        b_we,
    input  logic [2:0]  b_addr,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_irq,
    output logic        b_nmi
);

    mu_bus_t bus_a, bus_b;
    assign bus_a = '{sel: a_sel, we: a_we, addr: a_addr, wdata: a_wdata};
    assign bus_b = '{sel: b_sel, we: b_we, addr: b_addr, wdata: b_wdata};

    logic [N_SLOTS-1:0]             wr_ab, rd_ab, occ_ab, wr_ba, rd_ba, occ_ba;
    logic [N_SLOTS-1:0][DATA_W-1:0] dat_ab, dat_ba;
    logic [DATA_W-1:0]              txd_a, txd_b;
    logic [FLAG_W-1:0]              far_a, far_b;
    logic [N_GPI-1:0]               req_a, req_b, ack_a, ack_b;
    logic                           nreq_a, nreq_b, nack_a, nack_b;

    mu_msg_channel #(.N_SLOTS(N_SLOTS), .W(DATA_W)) u_ch_ab (
        .clk(clk), .rst(rst), .wr_en(wr_ab), .wr_data(txd_a),
        .rd_en(rd_ab), .occ_o(occ_ab), .data_o(dat_ab));

    mu_msg_channel #(.N_SLOTS(N_SLOTS), .W(DATA_W)) u_ch_ba (
        .clk(clk), .rst(rst), .wr_en(wr_ba), .wr_data(txd_b),
        .rd_en(rd_ba), .occ_o(occ_ba), .data_o(dat_ba));

    mu_side #(.N_SLOTS(N_SLOTS), .N_GPI(N_GPI), .PROP_CYCLES(PROP_CYCLES)) u_side_a (
        .clk(clk), .rst(rst), .bus_i(bus_a), .rdata_o(a_rdata),
        .rx_full_i(occ_ba), .rx_data_i(dat_ba), .rx_rd_o(rd_ba),
        .tx_occ_i(occ_ab), .tx_wr_o(wr_ab), .tx_data_o(txd_a),
        .flags_far_o(far_a), .flags_far_i(far_b),
        .gp_req_o(req_a), .gp_pend_i(req_b), .gp_ack_o(ack_a), .gp_ack_i(ack_b),
        .nmi_req_o(nreq_a), .nmi_pend_i(nreq_b), .nmi_ack_o(nack_a), .nmi_ack_i(nack_b),
        .irq_o(a_irq));

    mu_side #(.N_SLOTS(N_SLOTS), .N_GPI(N_GPI), .PROP_CYCLES(PROP_CYCLES)) u_side_b (
        .clk(clk), .rst(rst), .bus_i(bus_b), .rdata_o(b_rdata),
        .rx_full_i(occ_ab), .rx_data_i(dat_ab), .rx_rd_o(rd_ab),
        .tx_occ_i(occ_ba), .tx_wr_o(wr_ba), .tx_data_o(txd_b),
        .flags_far_o(far_b), .flags_far_i(far_a),
        .gp_req_o(req_b), .gp_pend_i(req_a), .gp_ack_o(ack_b), .gp_ack_i(ack_a),
        .nmi_req_o(nreq_b), .nmi_pend_i(nreq_a), .nmi_ack_o(nack_b), .nmi_ack_i(nack_a),
        .irq_o(b_irq));

    assign a_nmi = nreq_b;
    assign b_nmi = nreq_a;

endmodule

// File: tb/sim_mu_dual_top.sv
`timescale 1ns/1ps
module sim_mu_dual_top;

    localparam int P = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        sel [2];
    logic        we [2];
    logic [2:0]  addr [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic        irq [2];
    logic        nmi [2];

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    mu_dual_top #(.PROP_CYCLES(P)) u0 (
        .clk(clk), .rst(rst),
        .a_sel(sel[0]), .a_we(we[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
        .a_rdata(rdata[0]), .a_irq(irq[0]), .a_nmi(nmi[0]),
        .b_sel(sel[1]), .b_we(we[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
        .b_rdata(rdata[1]), .b_irq(irq[1]), .b_nmi(nmi[1]));

    // ---------------- behavioural reference model ----------------
    bit          occ [2][4];      // occ[s][n]: slot n written by side s
    logic [31:0] dat [2][4];
    logic [2:0]  flg [2], far [2], prv [2];
    bit          busy [2], evt [2], nmi_r [2], fee [2];
    int          cnt [2];
    bit   [3:0]  req [2], rxen [2], gpen [2];

    function automatic bit cwr(int s);
        return sel[s] && we[s] && addr[s] == 3'd4;
    endfunction
    function automatic bit swr(int s);
        return sel[s] && we[s] && addr[s] == 3'd5;
    endfunction

    always @(posedge clk) begin : model
        bit [3:0] ack [2];
        bit       nack [2];
        logic [2:0] far_old [2];
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                for (int n = 0; n < 4; n++) begin occ[s][n] = 0; dat[s][n] = '0; end
                flg[s] = 0; far[s] = 0; prv[s] = 0; busy[s] = 0; evt[s] = 0;
                nmi_r[s] = 0; fee[s] = 0; cnt[s] = 0; req[s] = 0; rxen[s] = 0; gpen[s] = 0;
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                ack[t] = 0;
                for (int g = 0; g < 4; g++)
                    ack[t][g] = swr(t) && wdata[t][31-g] && req[1-t][g];
                nack[t] = swr(t) && wdata[t][3] && nmi_r[1-t];
                far_old[t] = far[t];
            end
            for (int s = 0; s < 2; s++) begin
                evt[s] = (evt[s] && !(swr(s) && wdata[s][5])) || (far_old[1-s] != prv[s]);
                prv[s] = far_old[1-s];
                for (int n = 0; n < 4; n++) begin
                    if (sel[s] && we[s] && addr[s] == n && !occ[s][n]) begin
                        occ[s][n] = 1; dat[s][n] = wdata[s];
                    end else if (sel[1-s] && !we[1-s] && addr[1-s] == n && occ[s][n]) begin
                        occ[s][n] = 0;
                    end
                end
            end
            for (int s = 0; s < 2; s++) begin
                if (cwr(s)) begin
                    for (int g = 0; g < 4; g++) begin
                        if (wdata[s][19-g]) req[s][g] = 1;
                        gpen[s][g] = wdata[s][27-g];
                        rxen[s][g] = wdata[s][23-g];
                    end
                    if (wdata[s][3]) nmi_r[s] = 1;
                    fee[s] = wdata[s][28];
                end
                req[s] = req[s] & ~ack[1-s];
                if (nack[1-s]) nmi_r[s] = 0;
                if (busy[s]) begin
                    if (cnt[s] == 1) begin far[s] = flg[s]; busy[s] = 0; end
                    else cnt[s] = cnt[s] - 1;
                end else if (cwr(s) && wdata[s][2:0] != flg[s]) begin
                    flg[s] = wdata[s][2:0]; busy[s] = 1; cnt[s] = P;
                end
            end
        end
    end

    function automatic logic [31:0] exp_ctrl(int s);
        logic [31:0] v = '0;
        v[2:0] = flg[s]; v[3] = nmi_r[s]; v[28] = fee[s];
        for (int i = 0; i < 4; i++) begin
            v[19-i] = req[s][i]; v[23-i] = rxen[s][i]; v[27-i] = gpen[s][i];
        end
        return v;
    endfunction
    function automatic logic [31:0] exp_stat(int s);
        logic [31:0] v = '0;
        v[2:0] = far[1-s]; v[3] = nmi_r[1-s]; v[4] = busy[s]; v[5] = evt[s];
        for (int i = 0; i < 4; i++) begin
            v[23-i] = !occ[s][i]; v[27-i] = occ[1-s][i]; v[31-i] = req[1-s][i];
        end
        return v;
    endfunction
    function automatic bit exp_irq(int s);
        bit r = evt[s] && fee[s];
        for (int i = 0; i < 4; i++)
            r = r || (occ[1-s][i] && rxen[s][i]) || (req[1-s][i] && gpen[s][i]);
        return r;
    endfunction

    task automatic cmp(string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", rq, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int s = 0; s < 2; s++) begin
                cmp("R9 model irq", 32'(irq[s]), 32'(exp_irq(s)));
                cmp("R8 model nmi", 32'(nmi[s]), 32'(nmi_r[1-s]));
                if (sel[s] && !we[s]) begin
                    if (addr[s] < 3'd4)       cmp("R3 model slot", rdata[s], dat[1-s][addr[s]]);
                    else if (addr[s] == 3'd4) cmp("R7 model ctrl", rdata[s], exp_ctrl(s));
                    else if (addr[s] == 3'd5) cmp("R4 model status", rdata[s], exp_stat(s));
                    else                      cmp("R1 model unmapped", rdata[s], 32'h0);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int s, logic [2:0] a, logic [31:0] d);
        sel[s] = 1; we[s] = 1; addr[s] = a; wdata[s] = d;
        @(posedge clk); #2;
        sel[s] = 0; we[s] = 0;
    endtask
    task automatic rd(int s, logic [2:0] a, output logic [31:0] v);
        sel[s] = 1; we[s] = 0; addr[s] = a;
        @(negedge clk); v = rdata[s];
        @(posedge clk); #2;
        sel[s] = 0;
    endtask
    task automatic idle(int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin sel[s] = 0; we[s] = 0; addr[s] = 0; wdata[s] = 0; end
        repeat (3) @(posedge clk); #2;
        rst = 0;

        // R1 reset state
        rd(0, 3'd5, v); cmp("R1 A status", v, 32'h00F0_0000);
        rd(1, 3'd5, v); cmp("R1 B status", v, 32'h00F0_0000);
        rd(1, 3'd4, v); cmp("R1 B ctrl", v, 32'h0);
        cmp("R1 irq/nmi", {irq[0], irq[1], nmi[0], nmi[1]}, 32'h0);

        // R2 write slot 2, then overwrite attempt
        wr(0, 3'd2, 32'hCAFE_0002);
        rd(1, 3'd5, v); cmp("R2 B rx full bit 25", v, 32'h02F0_0000);
        rd(0, 3'd5, v); cmp("R2 A tx empty bit 21 cleared", v, 32'h00D0_0000);
        wr(0, 3'd2, 32'hDEAD_0000);
        rd(1, 3'd2, v); cmp("R2 word kept", v, 32'hCAFE_0002);
        // R3 read drained the slot
        rd(0, 3'd5, v); cmp("R3 A tx empty again", v, 32'h00F0_0000);
        rd(1, 3'd5, v); cmp("R3 B rx full cleared", v, 32'h00F0_0000);

        // R4 descending layout, slots 0 and 3 in B->A direction
        wr(1, 3'd0, 32'h1111_0000);
        wr(1, 3'd3, 32'h3333_0003);
        rd(0, 3'd5, v); cmp("R4 rx full bits 27 and 24", v, 32'h09F0_0000);
        rd(1, 3'd5, v); cmp("R4 tx empty bits 22 and 21", v, 32'h0060_0000);
        rd(0, 3'd0, v); cmp("R3 slot 0 data", v, 32'h1111_0000);
        rd(0, 3'd3, v); cmp("R3 slot 3 data", v, 32'h3333_0003);

        // R5/R6 flag propagation and lock
        wr(0, 3'd4, 32'h5);
        rd(0, 3'd5, v); cmp("R5 busy set", v, 32'h00F0_0010);
        wr(0, 3'd4, 32'h2);                      // lands on the release edge
        rd(1, 3'd5, v); cmp("R5 far flags visible", v, 32'h00F0_0005);
        rd(1, 3'd5, v); cmp("R10 change event set", v, 32'h00F0_0025);
        rd(0, 3'd4, v); cmp("R6 flags kept at 5", v, 32'h5);
        rd(0, 3'd5, v); cmp("R5 busy cleared", v, 32'h00F0_0000);
        wr(1, 3'd5, 32'h20);
        rd(1, 3'd5, v); cmp("R10 event cleared", v, 32'h00F0_0005);

        // R7 general request, write-0 and partner ack
        wr(0, 3'd4, 32'h0004_0005);
        rd(1, 3'd5, v); cmp("R7 B pending bit 30", v, 32'h40F0_0005);
        wr(0, 3'd4, 32'h0000_0005);
        rd(0, 3'd4, v); cmp("R7 write 0 keeps request", v, 32'h0004_0005);
        wr(1, 3'd5, 32'h0);
        rd(0, 3'd4, v); cmp("R7 zero ack keeps request", v, 32'h0004_0005);
        wr(1, 3'd5, 32'h4000_0000);
        rd(0, 3'd4, v); cmp("R7 ack clears request", v, 32'h0000_0005);

        // R8 non-maskable request
        wr(1, 3'd4, 32'h8);
        cmp("R8 A nmi high", 32'(nmi[0]), 32'h1);
        rd(0, 3'd5, v); cmp("R8 A status bit 3", v, 32'h00F0_0008);
        wr(0, 3'd5, 32'h8);
        cmp("R8 A nmi cleared", 32'(nmi[0]), 32'h0);
        rd(1, 3'd4, v); cmp("R8 B request cleared", v, 32'h0);

        // R9 interrupt gating
        wr(1, 3'd4, 32'h0080_0000);
        cmp("R9 no irq yet", 32'(irq[1]), 32'h0);
        wr(0, 3'd0, 32'h0000_0123);
        cmp("R9 rx full irq", 32'(irq[1]), 32'h1);
        rd(1, 3'd0, v); cmp("R3 slot 0 word", v, 32'h0000_0123);
        cmp("R9 irq drops after read", 32'(irq[1]), 32'h0);
        wr(1, 3'd4, 32'h0800_0000);
        wr(0, 3'd4, 32'h0008_0005);
        cmp("R9 gp irq", 32'(irq[1]), 32'h1);
        wr(1, 3'd5, 32'h8000_0000);
        cmp("R9 gp irq acked", 32'(irq[1]), 32'h0);
        wr(1, 3'd5, 32'h20);
        wr(1, 3'd4, 32'h1000_0000);
        wr(0, 3'd4, 32'h0000_0003);
        idle(4);
        cmp("R10 flag event irq", 32'(irq[1]), 32'h1);
        wr(1, 3'd5, 32'h20);
        cmp("R10 event irq cleared", 32'(irq[1]), 32'h0);
        idle(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule